// File: doc/BRIEF.md
# Interrupt Acknowledge Cycle Sequencer

This block drives the bus activity that follows the acceptance of a maskable interrupt and precedes the first instruction fetch of its handler. A one-cycle accept strobe starts a fixed schedule of fourteen phases. The schedule runs two external acknowledge cycles, fetches the new instruction pointer and code segment from the vector table, and pushes the flags, the old code segment and the old instruction pointer onto the stack. Idle gaps separate these steps. The whole schedule takes 55 clocks, and a one-cycle handler-start pulse then hands control to the fetch logic.

The vector number is taken from the data bus during the second acknowledge. It is scaled by four to form the table address. The stack pointer is stepped down by two ahead of every push, and each push lands at the segment-relative stack address. The interrupt-enable and trap flags are cleared once the flags push is complete. The phase lengths are a parameter table, and elaboration rejects any table whose entries do not add up to 55 or that holds a zero-length phase.

Top module: `intack_seq`

## Requirements
- R1: After reset, busy is 0, handler_start is 0, bus_kind is 0 (no cycle), and bus_addr and bus_wdata are 0.
- R2: Once accept is taken, the sequencer steps through phases of lengths 5,4,2,4,5,4,3,4,4,4,3,4,4,5 clocks. The bus_kind codes for these phases are 1,0,1,0,2,0,2,0,3,0,3,3,0,0, where 0 means none, 1 acknowledge, 2 read and 3 write. busy is 1 throughout the schedule.
- R3: handler_start is high for exactly one cycle, 55 clocks after the edge that takes accept. busy is 0 in that same cycle.
- R4: The vector is sampled from vec_in on the last clock of the second acknowledge phase. Reads go to vector*4 for the instruction pointer and to vector*4+2 for the code segment. During acknowledge and idle phases, bus_addr and bus_wdata are 0.
- R5: rd_data is sampled on the last clock of each read phase. It is presented on handler_ip (from the first read) and on handler_cs (from the second read).
- R6: Before each of the three pushes, the stack pointer drops by 2 (modulo 2^16). Each write goes to ss*16 + sp (modulo 2^20) and carries, in order, the flags, the code segment and the instruction pointer captured at acceptance. sp_out ends at sp_in-6.
- R7: During the flags push, flags_out equals the captured flags. From the end of that push onward, bit 9 (interrupt enable) and bit 8 (trap) of flags_out read 0, and the other bits are kept.
- R8: An accept strobe that arrives while busy is 1 has no effect. The schedule, its addresses and its 55-clock length are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| accept | input | 1 | Interrupt-accepted strobe |
| vec_in | input | 8 | Vector byte from the acknowledge data bus |
| rd_data | input | 16 | Read data for vector-table reads |
| flags_in | input | 16 | Current flags word |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 16 | Current instruction pointer |
| ss_in | input | 16 | Current stack segment |
| sp_in | input | 16 | Current stack pointer |
| busy | output | 1 | Sequence in progress |
| bus_kind | output | 2 | Cycle type: 0 none, 1 acknowledge, 2 read, 3 write |
| bus_addr | output | 20 | Cycle address |
| bus_wdata | output | 16 | Write data for pushes |
| handler_start | output | 1 | One-cycle start-of-handler pulse |
| handler_ip | output | 16 | Instruction pointer read from the table |
| handler_cs | output | 16 | Code segment read from the table |
| flags_out | output | 16 | Flags after the IF/TF clear |
| sp_out | output | 16 | Stack pointer after the pushes |

## Verification
Every output comes from a register with no extra stage. So the phase seen in the cycle after edge i (counting the accept edge as 0) follows from the running sum of the phase lengths, and handler_start is due exactly 55 edges after acceptance. The bench drives inputs and samples outputs on the falling edge, and it walks cycle indices 0 to 55 against that running sum. The vector is presented only during the second acknowledge phase and read data is answered from the address shown one half-cycle earlier, so a capture taken on the wrong clock gives a wrong address or a wrong handler value. The sweep covers all 256 vectors with varied stack pointers, including wrap-around, and it injects an extra strobe in the middle of some runs.

// File: rtl/intack_pkg.sv
package intack_pkg;
   localparam int NUM_PHASES = 14;
   localparam int LEN_W      = 8;

   typedef enum logic [1:0] {
      BK_NONE  = 2'd0,
      BK_ACK   = 2'd1,
      BK_READ  = 2'd2,
      BK_WRITE = 2'd3
   } bus_kind_t;

   typedef enum logic [3:0] {
      PH_ACK1    = 4'd0,
      PH_GAP1    = 4'd1,
      PH_ACK2    = 4'd2,
      PH_GAP2    = 4'd3,
      PH_RD_IP   = 4'd4,
      PH_GAP3    = 4'd5,
      PH_RD_CS   = 4'd6,
      PH_GAP4    = 4'd7,
      PH_PUSH_FL = 4'd8,
      PH_GAP5    = 4'd9,
      PH_PUSH_CS = 4'd10,
      PH_PUSH_IP = 4'd11,
      PH_GAP6    = 4'd12,
      PH_LEAD    = 4'd13
   } phase_t;

   typedef logic [NUM_PHASES-1:0][LEN_W-1:0] len_table_t;

   localparam len_table_t DEFAULT_LEN = {
      8'd5, 8'd4, 8'd4, 8'd3, 8'd4, 8'd4, 8'd4,
      8'd3, 8'd4, 8'd5, 8'd4, 8'd2, 8'd4, 8'd5
   };

   function automatic int len_sum(len_table_t t);
      int s;
      s = 0;
      for (int k = 0; k < NUM_PHASES; k++) s += int'(t[k]);
      return s;
   endfunction

   function automatic int len_min(len_table_t t);
      int m;
      m = int'(t[0]);
      for (int k = 1; k < NUM_PHASES; k++)
         if (int'(t[k]) < m) m = int'(t[k]);
      return m;
   endfunction

   function automatic bus_kind_t kind_of(phase_t p);
      case (p)
         PH_ACK1, PH_ACK2:                    return BK_ACK;
         PH_RD_IP, PH_RD_CS:                  return BK_READ;
         PH_PUSH_FL, PH_PUSH_CS, PH_PUSH_IP:  return BK_WRITE;
         default:                             return BK_NONE;
      endcase
   endfunction
endpackage

// File: rtl/intack_phase_timer.sv
module intack_phase_timer
   import intack_pkg::*;
#(
   parameter len_table_t PHASE_LEN = DEFAULT_LEN,
   parameter int         TOTAL     = 55
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   accept,
   output logic   busy,
   output phase_t phase,
   output logic   last,
   output logic   advance,
   output logic   done
);
   localparam int SUM = len_sum(PHASE_LEN);
   localparam int MIN = len_min(PHASE_LEN);

   if (SUM != TOTAL) begin : g_bad_total
      $error("phase table sums to %0d, expected %0d", SUM, TOTAL);
   end
   if (MIN < 1) begin : g_bad_len
      $error("phase table holds a zero-length phase");
   end

   logic [LEN_W-1:0] cnt;
   logic [LEN_W-1:0] cur_len;

   assign cur_len = PHASE_LEN[phase];
   assign last    = busy && (cnt == cur_len - LEN_W'(1));
   assign advance = last && (phase != PH_LEAD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         phase <= PH_ACK1;
         cnt   <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (accept) begin
               busy  <= 1'b1;
               phase <= PH_ACK1;
               cnt   <= '0;
            end
         end else if (last) begin
            cnt <= '0;
            if (phase == PH_LEAD) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               phase <= phase_t'(4'(phase) + 4'd1);
            end
         end else begin
            cnt <= cnt + LEN_W'(1);
         end
      end
   end

   // R2: a phase holds until its last clock, then steps by exactly one
   p_phase_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last) |=> (busy && phase == $past(phase)));
   p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      advance |=> (busy && 4'(phase) == 4'($past(phase)) + 4'd1 && cnt == '0));

   // R3: the start pulse lasts one cycle and follows the end of busy
   p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R8: a strobe inside the schedule never restarts it
   p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && accept && !(last && phase == PH_LEAD))
         |=> (busy && 4'(phase) >= 4'($past(phase))));
endmodule

// File: rtl/intack_datapath.sv
module intack_datapath
   import intack_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int ADDR_W     = 20,
   parameter int VEC_W      = 8,
   parameter int SEG_SHIFT  = 4,
   parameter int VEC_SCALE  = 2,
   parameter int SP_STEP    = 2,
   parameter int IF_BIT     = 9,
   parameter int TF_BIT     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              busy,
   input  phase_t            phase,
   input  logic              last,
   input  logic              advance,
   input  logic [VEC_W-1:0]  vec_in,
   input  logic [DATA_W-1:0] rd_data,
   input  logic [DATA_W-1:0] flags_in,
   input  logic [DATA_W-1:0] cs_in,
   input  logic [DATA_W-1:0] ip_in,
   input  logic [DATA_W-1:0] ss_in,
   input  logic [DATA_W-1:0] sp_in,
   output logic [VEC_W-1:0]  vec_q,
   output logic [DATA_W-1:0] flags_q,
   output logic [DATA_W-1:0] cs_q,
   output logic [DATA_W-1:0] ip_q,
   output logic [DATA_W-1:0] sp_q,
   output logic [ADDR_W-1:0] stack_addr,
   output logic [DATA_W-1:0] new_ip,
   output logic [DATA_W-1:0] new_cs
);
   localparam int SEG_EXT = DATA_W + SEG_SHIFT;

   if (ADDR_W < VEC_W + VEC_SCALE) begin : g_bad_vec
      $error("address too narrow for the scaled vector");
   end
   if (IF_BIT >= DATA_W || TF_BIT >= DATA_W) begin : g_bad_flag
      $error("flag bit outside the data word");
   end
   if (SEG_EXT < ADDR_W) begin : g_bad_seg
      $error("segment shift too small for the address width");
   end

   logic [DATA_W-1:0] ss_q;
   logic              enter_push;
   logic [SEG_EXT-1:0] seg_sum;

   assign enter_push = advance &&
      (phase == PH_GAP4 || phase == PH_GAP5 || phase == PH_PUSH_CS);

   assign seg_sum    = {ss_q, {SEG_SHIFT{1'b0}}} + SEG_EXT'(sp_q);
   assign stack_addr = seg_sum[ADDR_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vec_q   <= '0;
         flags_q <= '0;
         cs_q    <= '0;
         ip_q    <= '0;
         ss_q    <= '0;
         sp_q    <= '0;
         new_ip  <= '0;
         new_cs  <= '0;
      end else begin
         if (!busy && accept) begin
            flags_q <= flags_in;
            cs_q    <= cs_in;
            ip_q    <= ip_in;
            ss_q    <= ss_in;
            sp_q    <= sp_in;
         end
         if (last && phase == PH_ACK2)  vec_q  <= vec_in;
         if (last && phase == PH_RD_IP) new_ip <= rd_data;
         if (last && phase == PH_RD_CS) new_cs <= rd_data;
         if (last && phase == PH_PUSH_FL) begin
            flags_q[IF_BIT] <= 1'b0;
            flags_q[TF_BIT] <= 1'b0;
         end
         if (enter_push) sp_q <= sp_q - DATA_W'(SP_STEP);
      end
   end

   // R6: inside a schedule the stack pointer only ever moves down by one step
   p_sp_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy) && busy && sp_q != $past(sp_q))
         |-> (sp_q == $past(sp_q) - DATA_W'(SP_STEP)));

   // R7: past the flags push both control flags read zero
   p_flags_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && 4'(phase) > 4'(PH_PUSH_FL)) |-> (!flags_q[IF_BIT] && !flags_q[TF_BIT]));

   // R4: the vector stays put once the second acknowledge is over
   p_vec_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy) && busy && 4'($past(phase)) > 4'(PH_ACK2)) |-> $stable(vec_q));
endmodule

// File: rtl/intack_bus_drive.sv
module intack_bus_drive
   import intack_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 20,
   parameter int VEC_W     = 8,
   parameter int VEC_SCALE = 2
) (
   input  logic              busy,
   input  phase_t            phase,
   input  logic [VEC_W-1:0]  vec_q,
   input  logic [ADDR_W-1:0] stack_addr,
   input  logic [DATA_W-1:0] flags_q,
   input  logic [DATA_W-1:0] cs_q,
   input  logic [DATA_W-1:0] ip_q,
   output logic [1:0]        bus_kind,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata
);
   localparam int PAD_W = ADDR_W - VEC_W - VEC_SCALE;

   logic [ADDR_W-1:0] tbl_ip_addr;
   logic [ADDR_W-1:0] tbl_cs_addr;

   if (PAD_W > 0) begin : g_pad
      assign tbl_ip_addr = {{PAD_W{1'b0}}, vec_q, {VEC_SCALE{1'b0}}};
   end else begin : g_nopad
      assign tbl_ip_addr = {vec_q, {VEC_SCALE{1'b0}}};
   end

   // with a scale of four or more the +2 never carries, so an OR is enough
   if (VEC_SCALE >= 2) begin : g_or_off
      assign tbl_cs_addr = tbl_ip_addr | ADDR_W'(2);
   end else begin : g_add_off
      assign tbl_cs_addr = tbl_ip_addr + ADDR_W'(2);
   end

   always_comb begin
      bus_kind  = busy ? 2'(kind_of(phase)) : 2'(BK_NONE);
      bus_addr  = '0;
      bus_wdata = '0;
      if (busy) begin
         case (phase)
            PH_RD_IP:   bus_addr = tbl_ip_addr;
            PH_RD_CS:   bus_addr = tbl_cs_addr;
            PH_PUSH_FL: begin bus_addr = stack_addr; bus_wdata = flags_q; end
            PH_PUSH_CS: begin bus_addr = stack_addr; bus_wdata = cs_q;    end
            PH_PUSH_IP: begin bus_addr = stack_addr; bus_wdata = ip_q;    end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/intack_seq.sv
module intack_seq
   import intack_pkg::*;
#(
   parameter int         DATA_W    = 16,
   parameter int         ADDR_W    = 20,
   parameter int         VEC_W     = 8,
   parameter int         SEG_SHIFT = 4,
   parameter int         VEC_SCALE = 2,
   parameter int         SP_STEP   = 2,
   parameter int         IF_BIT    = 9,
   parameter int         TF_BIT    = 8,
   parameter int         TOTAL     = 55,
   parameter len_table_t PHASE_LEN = DEFAULT_LEN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [VEC_W-1:0]  vec_in,
   input  logic [DATA_W-1:0] rd_data,
   input  logic [DATA_W-1:0] flags_in,
   input  logic [DATA_W-1:0] cs_in,
   input  logic [DATA_W-1:0] ip_in,
   input  logic [DATA_W-1:0] ss_in,
   input  logic [DATA_W-1:0] sp_in,
   output logic              busy,
   output logic [1:0]        bus_kind,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   output logic              handler_start,
   output logic [DATA_W-1:0] handler_ip,
   output logic [DATA_W-1:0] handler_cs,
   output logic [DATA_W-1:0] flags_out,
   output logic [DATA_W-1:0] sp_out
);
   phase_t            phase;
   logic              last;
   logic              advance;
   logic [VEC_W-1:0]  vec_q;
   logic [DATA_W-1:0] cs_q;
   logic [DATA_W-1:0] ip_q;
   logic [ADDR_W-1:0] stack_addr;

   intack_phase_timer #(
      .PHASE_LEN (PHASE_LEN),
      .TOTAL     (TOTAL)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .accept  (accept),
      .busy    (busy),
      .phase   (phase),
      .last    (last),
      .advance (advance),
      .done    (handler_start)
   );

   intack_datapath #(
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .VEC_W     (VEC_W),
      .SEG_SHIFT (SEG_SHIFT),
      .VEC_SCALE (VEC_SCALE),
      .SP_STEP   (SP_STEP),
      .IF_BIT    (IF_BIT),
      .TF_BIT    (TF_BIT)
   ) u_dp (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .busy       (busy),
      .phase      (phase),
      .last       (last),
      .advance    (advance),
      .vec_in     (vec_in),
      .rd_data    (rd_data),
      .flags_in   (flags_in),
      .cs_in      (cs_in),
      .ip_in      (ip_in),
      .ss_in      (ss_in),
      .sp_in      (sp_in),
      .vec_q      (vec_q),
      .flags_q    (flags_out),
      .cs_q       (cs_q),
      .ip_q       (ip_q),
      .sp_q       (sp_out),
      .stack_addr (stack_addr),
      .new_ip     (handler_ip),
      .new_cs     (handler_cs)
   );

   intack_bus_drive #(
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .VEC_W     (VEC_W),
      .VEC_SCALE (VEC_SCALE)
   ) u_bus (
      .busy       (busy),
      .phase      (phase),
      .vec_q      (vec_q),
      .stack_addr (stack_addr),
      .flags_q    (flags_out),
      .cs_q       (cs_q),
      .ip_q       (ip_q),
      .bus_kind   (bus_kind),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata)
   );

   // R1: no bus cycle is requested outside a schedule
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (bus_kind == 2'd0 && bus_addr == '0 && bus_wdata == '0));
endmodule

// File: tb/tb_intack_seq.sv
module tb_intack_seq;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        accept;
   logic [7:0]  vec_in;
   logic [15:0] rd_data, flags_in, cs_in, ip_in, ss_in, sp_in;
   logic        busy, handler_start;
   logic [1:0]  bus_kind;
   logic [19:0] bus_addr;
   logic [15:0] bus_wdata, handler_ip, handler_cs, flags_out, sp_out;

   int total = 0;
   int bad   = 0;
   bit ended = 0;

   always #4 clk = ~clk;

   intack_seq dut (
      .clk(clk), .rst_n(rst_n), .accept(accept), .vec_in(vec_in),
      .rd_data(rd_data), .flags_in(flags_in), .cs_in(cs_in), .ip_in(ip_in),
      .ss_in(ss_in), .sp_in(sp_in), .busy(busy), .bus_kind(bus_kind),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .handler_start(handler_start),
      .handler_ip(handler_ip), .handler_cs(handler_cs), .flags_out(flags_out),
      .sp_out(sp_out)
   );

   int lens  [14] = '{5,4,2,4,5,4,3,4,4,4,3,4,4,5};
   int kinds [14] = '{1,0,1,0,2,0,2,0,3,0,3,3,0,0};

   function automatic logic [15:0] mem(logic [19:0] a);
      return a[15:0] ^ 16'h5A3C ^ {a[19:16], 12'h0};
   endfunction

   function automatic logic [19:0] phys(logic [15:0] s, logic [15:0] o);
      return ({4'h0, s} << 4) + {4'h0, o};
   endfunction

   function automatic int phase_at(int i);
      int acc;
      acc = 0;
      for (int p = 0; p < 14; p++) begin
         acc += lens[p];
         if (i < acc) return p;
      end
      return 14;
   endfunction

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic run(logic [7:0] v, logic [15:0] fl, logic [15:0] cs,
                      logic [15:0] ip, logic [15:0] ss, logic [15:0] sp, bit poke);
      logic [19:0] ea;
      logic [15:0] ew;
      logic [15:0] sp_exp;
      @(negedge clk);
      flags_in = fl; cs_in = cs; ip_in = ip; ss_in = ss; sp_in = sp;
      vec_in = ~v; accept = 1'b1;
      @(negedge clk);
      accept = 1'b0;
      // change the live inputs: the captured copies must be used
      flags_in = ~fl; cs_in = ~cs; ip_in = ~ip; sp_in = ~sp;
      for (int i = 0; i < 55; i++) begin
         int p;
         p = phase_at(i);
         chk(busy == 1'b1, "R2 busy", 32'(busy), 1);
         chk(handler_start == 1'b0, "R3 early start", 32'(handler_start), 0);
         chk(int'(bus_kind) == kinds[p], "R2 kind", 32'(bus_kind), 32'(kinds[p]));
         ea = '0; ew = '0;
         case (p)
            4:  ea = {10'h0, v, 2'b00};
            6:  ea = {10'h0, v, 2'b10};
            8:  begin ea = phys(ss, sp - 16'd2); ew = fl; end
            10: begin ea = phys(ss, sp - 16'd4); ew = cs; end
            11: begin ea = phys(ss, sp - 16'd6); ew = ip; end
            default: ;
         endcase
         if (p == 4 || p == 6)
            chk(bus_addr == ea, "R4 table addr", 32'(bus_addr), 32'(ea));
         else if (p == 8 || p == 10 || p == 11) begin
            chk(bus_addr == ea, "R6 push addr", 32'(bus_addr), 32'(ea));
            chk(bus_wdata == ew, "R6 push data", 32'(bus_wdata), 32'(ew));
         end else begin
            chk(bus_addr == '0 && bus_wdata == '0, "R4 quiet addr",
                32'(bus_addr), 0);
         end
         if (p == 8)
            chk(flags_out == fl, "R7 flags before", 32'(flags_out), 32'(fl));
         if (p >= 9)
            chk(flags_out == (fl & 16'hFCFF), "R7 flags cleared",
                32'(flags_out), 32'(fl & 16'hFCFF));
         vec_in  = (p == 2) ? v : ~v;
         rd_data = (bus_kind == 2'd2) ? mem(bus_addr) : 16'hDEAD;
         accept  = (poke && (i == 20 || i == 40 || i == 54)) ? 1'b1 : 1'b0;
         @(negedge clk);
      end
      accept = 1'b0;
      sp_exp = sp - 16'd6;
      chk(handler_start == 1'b1, "R3 start due", 32'(handler_start), 1);
      chk(busy == 1'b0, "R3 busy low", 32'(busy), 0);
      chk(handler_ip == mem({10'h0, v, 2'b00}), "R5 handler ip",
          32'(handler_ip), 32'(mem({10'h0, v, 2'b00})));
      chk(handler_cs == mem({10'h0, v, 2'b10}), "R5 handler cs",
          32'(handler_cs), 32'(mem({10'h0, v, 2'b10})));
      chk(sp_out == sp_exp, "R6 final sp", 32'(sp_out), 32'(sp_exp));
      @(negedge clk);
      chk(handler_start == 1'b0, "R3 single pulse", 32'(handler_start), 0);
      chk(busy == 1'b0, "R8 no restart", 32'(busy), 0);
      chk(bus_kind == 2'd0, "R8 quiet after", 32'(bus_kind), 0);
   endtask

   task automatic finish_up();
      if (!ended) begin
         ended = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(8 * 150000);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_up();
   end

   initial begin
      rst_n = 1'b0; accept = 1'b0; vec_in = '0; rd_data = '0;
      flags_in = '0; cs_in = '0; ip_in = '0; ss_in = '0; sp_in = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0, "R1 busy", 32'(busy), 0);
      chk(handler_start == 1'b0, "R1 start", 32'(handler_start), 0);
      chk(bus_kind == 2'd0, "R1 kind", 32'(bus_kind), 0);
      chk(bus_addr == '0 && bus_wdata == '0, "R1 bus", 32'(bus_addr), 0);
      // corner: stack pointer wraps below zero, all flags set
      run(8'h00, 16'hFFFF, 16'h1234, 16'h5678, 16'hF000, 16'h0000, 1'b0);
      run(8'hFF, 16'h0300, 16'hFFFF, 16'h0000, 16'hFFFF, 16'h0004, 1'b1);
      for (int v = 0; v < 256; v++) begin
         run(8'(v), 16'(v * 16'h0101) ^ 16'h0200, 16'(v * 7 + 3),
             16'(v * 13 + 1), 16'(v * 16'h0111), 16'(v * 16'h0102 + 2),
             (v % 5) == 0);
      end
      finish_up();
   end
endmodule